// File: doc/BRIEF.md
# Memory Card Protocol Responder

This block answers a console's memory-card traffic one byte at a time. The serial bus is framed by a select line, and a separate shifter, not part of this block, moves the bits. For each byte received from the host the shifter gives a strobe. The responder then works out the byte the card must shift out during the following exchange. It also says whether that exchange should be acknowledged. The reply therefore always runs one byte behind the command byte that caused it.

The responder decodes three operations: read a sector, write a sector and identify the card. It steps through the address phase and moves one sector of data through a simple memory port. Sector reads are combinational, so the data must be valid in the same cycle for the address shown. An XOR checksum runs over the sector address and the data, and it decides the closing status byte. Dropping select at any time abandons the frame.

A sticky dirty output is raised when a write to an ordinary sector completes. The surrounding system uses it to know that the backing copy needs flushing.

Top module: `mcard_responder`

## Requirements
- R1: In idle, a strobed byte 0x81 makes the next reply the current `flag_byte` value with acknowledge enabled. Any other byte gives reply 0xFF with acknowledge disabled, and the block stays idle.
- R2: After the start byte, command 0x52 (read), 0x57 (write) or 0x53 (identify) is answered with ID1 (0x5A). Any other command byte gives reply 0xFF with no acknowledge and a return to idle.
- R3: The byte after a valid command is answered with ID2 (0x5D). Identify then skips the address phase and returns 0x5C, 0x5D, 0x04, 0x00, 0x00, 0x80 in that order. The next byte gets 0xFF with no acknowledge, and the block goes back to idle.
- R4: The address phase answers three bytes in turn. The filler gets 0x00. The address high byte is echoed. The address low byte is echoed for a write, but a read answers it with ACK1 (0x5C).
- R5: A read replies in this order: ACK2 (0x5D), the address high byte, the address low byte, then the sector bytes at offsets 0 to SECTOR_BYTES-1, then the checksum, then the end status. `mem_addr` is sector × SECTOR_BYTES + offset.
- R6: The checksum starts as high byte XOR low byte of the sector address. Every data byte moved is then XORed into it. The end status is 0x47 when the host checksum equals the computed one and 0x4E otherwise. For a read, the host checksum is zero.
- R7: A write echoes each data byte. In the same cycle it asserts `mem_wr_en` with `mem_wr_data` = that byte at the matching `mem_addr`. The next byte is the host checksum and is answered with ACK1. The byte after that is answered with ACK2, and then comes the end status.
- R8: A sector address of NUM_SECTORS or more is refused. A read refuses in place of the high-byte echo and a write on its first data byte. The refusal is two replies of 0xFF, after which the block is idle, and no memory write is issued.
- R9: While `sel_active` is low, the block clears state, counters, address, checksums and the pending reply. The reply reads 0xFF with acknowledge off, and strobes are ignored.
- R10: `dirty` rises when a write to any sector other than TEST_SECTOR completes. It stays high until `rst_n`, including through deselection. A completed write to TEST_SECTOR leaves it unchanged.
- R11: After reset, `tx_byte` is 0xFF and `ack_en`, `dirty` and `mem_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_active | input | 1 | High while the card is selected on the bus |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete host byte |
| rx_byte | input | 8 | Byte received from the host |
| flag_byte | input | 8 | Card flag returned in answer to the start byte |
| tx_byte | output | 8 | Byte to shift out on the next exchange |
| ack_en | output | 1 | Acknowledge the next exchange |
| mem_addr | output | log2(NUM_SECTORS)+log2(SECTOR_BYTES) | Sector memory byte address |
| mem_rd_data | input | 8 | Sector memory read data, combinational from `mem_addr` |
| mem_wr_en | output | 1 | Sector memory write strobe |
| mem_wr_data | output | 8 | Sector memory write data |
| dirty | output | 1 | A non-test sector has been written since reset |

## Verification
The bench builds the responder with 8-byte sectors, 64 sectors and sector 5 as the test sector. A full read or write frame is then only a few dozen bytes, so whole transfers, checksums and end status can be compared byte by byte on every clock. With only 64 sectors, address 0x0040 is already out of range, which puts the refusal path next to legal sector numbers. Sector 5 gives a write that must leave `dirty` low before an ordinary write raises it. One sector is written with data chosen so that its read-back checksum is zero, which is the only way a read can end on the good status.

// File: rtl/mcr_pkg.sv
// Package: shared types and protocol byte values for the memory card responder.
// Assumes: 8-bit bus bytes; the command codes are fixed by the host protocol.
package mcr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ID2,
        ST_ADDR,
        ST_RD,
        ST_WR,
        ST_IDOUT,
        ST_ABORT,
        ST_END
    } mcr_state_e;

    typedef enum logic [1:0] {
        OP_RD,
        OP_WR,
        OP_IDENT
    } mcr_op_e;

    localparam logic [7:0] BYTE_START    = 8'h81;
    localparam logic [7:0] BYTE_OP_READ  = 8'h52;
    localparam logic [7:0] BYTE_OP_WRITE = 8'h57;
    localparam logic [7:0] BYTE_OP_IDENT = 8'h53;
    localparam logic [7:0] BYTE_IDLE_OUT = 8'hFF;
    localparam logic [7:0] IDENT_SIZE_HI = 8'h04;
    localparam logic [7:0] IDENT_LAST    = 8'h80;
    localparam int         IDENT_LEN     = 6;

endpackage

// File: rtl/mcr_step_counter.sv
// Module: byte position counter used by every multi-byte phase.
// Assumes: clear has priority over increment; never counts past LIMIT in use.
module mcr_step_counter #(
    parameter int LIMIT = 134,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    // Position register: reset or clear to zero, else step on increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R5: the phase logic never drives the position past the longest phase.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));

endmodule

// File: rtl/mcr_xor_sum.sv
// Module: running XOR checksum with seed and accumulate controls.
// Assumes: seed and accumulate may happen together (seed replaces old sum first).
module mcr_xor_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       seed_en,
    input  logic [7:0] seed,
    input  logic       acc_en,
    input  logic [7:0] acc,
    output logic [7:0] sum
);

    logic [7:0] sum_q;
    logic [7:0] base;

    // Start point for this update: fresh seed or the running value.
    always_comb base = seed_en ? seed : sum_q;

    // Checksum register: clear, or fold in the new byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
        end else if (seed_en || acc_en) begin
            sum_q <= base ^ (acc_en ? acc : 8'h00);
        end
    end

    assign sum = sum_q;

    // R6: without any control the checksum holds its value.
    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !seed_en && !acc_en) |=> (sum_q == $past(sum_q)));

endmodule

// File: rtl/mcr_sector_port.sv
// Module: forms the sector memory byte address and the sector range check.
// Assumes: SECTOR_BYTES and NUM_SECTORS are powers of two >= 2; read data
// offsets start three bytes into the read phase.
module mcr_sector_port #(
    parameter int SECTOR_BYTES = 128,
    parameter int NUM_SECTORS  = 1024,
    parameter int CNT_W        = 8,
    localparam int OFS_W       = $clog2(SECTOR_BYTES),
    localparam int SEC_W       = $clog2(NUM_SECTORS),
    localparam int MEM_AW      = SEC_W + OFS_W
) (
    input  logic [15:0]       sector,
    input  logic [CNT_W-1:0]  pos,
    input  logic              rd_phase,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              in_range
);

    logic [CNT_W-1:0] ofs_full;

    // Offset in the sector: reads lag the position by the three header bytes.
    always_comb ofs_full = rd_phase ? (pos - CNT_W'(3)) : pos;

    // Byte address and legality of the sector number.
    always_comb begin
        mem_addr = {sector[SEC_W-1:0], ofs_full[OFS_W-1:0]};
        in_range = ({16'h0000, sector} < 32'(NUM_SECTORS));
    end

endmodule

// File: rtl/mcard_responder.sv
// Module: byte-level memory card responder (top).
// Decodes start, command and address bytes, streams a sector through the
// memory port, keeps the XOR checksum and produces the reply byte and the
// acknowledge enable for the following exchange.
// Assumes: rx_valid is a single-cycle strobe; mem_rd_data is combinational
// from mem_addr; sel_active low means the frame is over.
module mcard_responder #(
    parameter int         SECTOR_BYTES = 128,
    parameter int         NUM_SECTORS  = 1024,
    parameter int         TEST_SECTOR  = 16'h003F,
    parameter logic [7:0] CODE_ACK1    = 8'h5C,
    parameter logic [7:0] CODE_ACK2    = 8'h5D,
    parameter logic [7:0] CODE_ID1     = 8'h5A,
    parameter logic [7:0] CODE_ID2     = 8'h5D,
    parameter logic [7:0] CODE_GOOD    = 8'h47,
    parameter logic [7:0] CODE_BADSUM  = 8'h4E,
    localparam int MEM_AW = $clog2(NUM_SECTORS) + $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_active,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        flag_byte,
    output logic [7:0]        tx_byte,
    output logic              ack_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wr_data,
    output logic              dirty
);
    import mcr_pkg::*;

    localparam int CNT_LIMIT = SECTOR_BYTES + 6;
    localparam int CNT_W     = $clog2(CNT_LIMIT + 1);
    localparam logic [CNT_W-1:0] POS_DATA_END = CNT_W'(SECTOR_BYTES + 3);
    localparam logic [CNT_W-1:0] POS_SECTOR   = CNT_W'(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] POS_IDENT    = CNT_W'(IDENT_LEN);

    mcr_state_e st_q, st_n;
    mcr_op_e    op_q, op_n;
    logic [7:0] msb_q, lsb_q, host_q, tx_q;
    logic       ack_q, dirty_q;

    logic [7:0] reply, acc_val, sum;
    logic       ack, cnt_clr_c, cnt_inc_c, msb_ld, lsb_ld;
    logic       sum_clr_c, seed_c, acc_c, host_clr, host_ld, set_dirty, wr_c;
    logic       step, in_range;
    logic [CNT_W-1:0] cnt;

    // One host byte is consumed only while selected.
    always_comb step = rx_valid && sel_active;

    // Identify response table, indexed by position.
    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return CODE_ACK1;
            3'd1:    return CODE_ACK2;
            3'd2:    return IDENT_SIZE_HI;
            3'd3:    return 8'h00;
            3'd4:    return 8'h00;
            default: return IDENT_LAST;
        endcase
    endfunction

    mcr_step_counter #(
        .LIMIT (CNT_LIMIT),
        .CNT_W (CNT_W)
    ) pos_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!sel_active || (step && cnt_clr_c)),
        .inc   (step && cnt_inc_c),
        .cnt   (cnt)
    );

    mcr_xor_sum sum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!sel_active || (step && sum_clr_c)),
        .seed_en (step && seed_c),
        .seed    (msb_q ^ lsb_q),
        .acc_en  (step && acc_c),
        .acc     (acc_val),
        .sum     (sum)
    );

    mcr_sector_port #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .NUM_SECTORS  (NUM_SECTORS),
        .CNT_W        (CNT_W)
    ) port_i (
        .sector   ({msb_q, lsb_q}),
        .pos      (cnt),
        .rd_phase (st_q == ST_RD),
        .mem_addr (mem_addr),
        .in_range (in_range)
    );

    // Protocol decode: next state, reply byte and side effects for this byte.
    always_comb begin
        st_n      = st_q;
        op_n      = op_q;
        reply     = BYTE_IDLE_OUT;
        ack       = 1'b1;
        cnt_clr_c = 1'b0;
        cnt_inc_c = 1'b0;
        msb_ld    = 1'b0;
        lsb_ld    = 1'b0;
        sum_clr_c = 1'b0;
        seed_c    = 1'b0;
        acc_c     = 1'b0;
        acc_val   = rx_byte;
        host_clr  = 1'b0;
        host_ld   = 1'b0;
        set_dirty = 1'b0;
        wr_c      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                cnt_clr_c = 1'b1;
                sum_clr_c = 1'b1;
                host_clr  = 1'b1;
                if (rx_byte == BYTE_START) begin
                    reply = flag_byte;
                    st_n  = ST_CMD;
                end else begin
                    ack = 1'b0;
                end
            end
            ST_CMD: begin
                reply = CODE_ID1;
                st_n  = ST_ID2;
                case (rx_byte)
                    BYTE_OP_READ:  op_n = OP_RD;
                    BYTE_OP_WRITE: op_n = OP_WR;
                    BYTE_OP_IDENT: op_n = OP_IDENT;
                    default: begin
                        reply = BYTE_IDLE_OUT;
                        ack   = 1'b0;
                        st_n  = ST_IDLE;
                    end
                endcase
            end
            ST_ID2: begin
                reply     = CODE_ID2;
                cnt_clr_c = 1'b1;
                st_n      = (op_q == OP_IDENT) ? ST_IDOUT : ST_ADDR;
            end
            ST_ADDR: begin
                if (cnt == '0) begin
                    reply     = 8'h00;
                    cnt_inc_c = 1'b1;
                end else if (cnt == CNT_W'(1)) begin
                    msb_ld    = 1'b1;
                    reply     = rx_byte;
                    cnt_inc_c = 1'b1;
                end else begin
                    lsb_ld    = 1'b1;
                    cnt_clr_c = 1'b1;
                    reply     = (op_q == OP_RD) ? CODE_ACK1 : rx_byte;
                    st_n      = (op_q == OP_RD) ? ST_RD : ST_WR;
                end
            end
            ST_RD: begin
                cnt_inc_c = 1'b1;
                if (cnt == '0) begin
                    reply  = CODE_ACK2;
                    seed_c = 1'b1;
                end else if (cnt == CNT_W'(1) || cnt == CNT_W'(2)) begin
                    if (in_range) begin
                        reply = (cnt == CNT_W'(1)) ? msb_q : lsb_q;
                    end else begin
                        st_n = ST_ABORT;
                    end
                end else if (cnt < POS_DATA_END) begin
                    reply   = mem_rd_data;
                    acc_c   = 1'b1;
                    acc_val = mem_rd_data;
                end else begin
                    reply = sum;
                    st_n  = ST_END;
                end
            end
            ST_WR: begin
                if (!in_range) begin
                    st_n = ST_ABORT;
                end else begin
                    cnt_inc_c = 1'b1;
                    if (cnt < POS_SECTOR) begin
                        wr_c   = 1'b1;
                        reply  = rx_byte;
                        acc_c  = 1'b1;
                        seed_c = (cnt == '0);
                    end else if (cnt == POS_SECTOR) begin
                        host_ld = 1'b1;
                        reply   = CODE_ACK1;
                    end else begin
                        reply     = CODE_ACK2;
                        set_dirty = ({msb_q, lsb_q} != 16'(TEST_SECTOR));
                        st_n      = ST_END;
                    end
                end
            end
            ST_IDOUT: begin
                if (cnt < POS_IDENT) begin
                    reply     = ident_byte(cnt[2:0]);
                    cnt_inc_c = 1'b1;
                end else begin
                    ack  = 1'b0;
                    st_n = ST_IDLE;
                end
            end
            ST_ABORT: begin
                st_n = ST_IDLE;
            end
            ST_END: begin
                reply = (host_q == sum) ? CODE_GOOD : CODE_BADSUM;
                st_n  = ST_IDLE;
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // Frame registers: reset, deselect clear, or advance on each host byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            op_q    <= OP_RD;
            msb_q   <= 8'h00;
            lsb_q   <= 8'h00;
            host_q  <= 8'h00;
            tx_q    <= BYTE_IDLE_OUT;
            ack_q   <= 1'b0;
            dirty_q <= 1'b0;
        end else if (!sel_active) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_RD;
            msb_q  <= 8'h00;
            lsb_q  <= 8'h00;
            host_q <= 8'h00;
            tx_q   <= BYTE_IDLE_OUT;
            ack_q  <= 1'b0;
        end else if (rx_valid) begin
            st_q  <= st_n;
            op_q  <= op_n;
            tx_q  <= reply;
            ack_q <= ack;
            if (msb_ld)    msb_q   <= rx_byte;
            if (lsb_ld)    lsb_q   <= rx_byte;
            if (host_clr)  host_q  <= 8'h00;
            else if (host_ld) host_q <= rx_byte;
            if (set_dirty) dirty_q <= 1'b1;
        end
    end

    assign tx_byte     = tx_q;
    assign ack_en      = ack_q;
    assign dirty       = dirty_q;
    assign mem_wr_en   = step && wr_c;
    assign mem_wr_data = rx_byte;

    // R1: a start byte in idle is answered with the flag byte and acknowledged.
    assert_start_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_IDLE && rx_byte == BYTE_START)
        |=> (tx_byte == $past(flag_byte)) && ack_en);

    // R1: any other byte in idle is not acknowledged.
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_IDLE && rx_byte != BYTE_START)
        |=> !ack_en && (tx_byte == BYTE_IDLE_OUT));

    // R2: an unknown command sends the block back to idle without acknowledge.
    assert_bad_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q == ST_CMD && rx_byte != BYTE_OP_READ
         && rx_byte != BYTE_OP_WRITE && rx_byte != BYTE_OP_IDENT)
        |=> !ack_en && (st_q == ST_IDLE));

    // R8: memory writes only ever target a legal sector.
    assert_write_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> in_range);

    // R9: deselection leaves an idle reply with no acknowledge.
    assert_desel_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |=> (tx_byte == BYTE_IDLE_OUT) && !ack_en && (st_q == ST_IDLE));

    // R10: once set, the dirty flag stays set until reset.
    assert_dirty_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |=> dirty);

endmodule

// File: tb/mcard_responder_tb.sv
// Bench: behavioural reference model of the card protocol, compared each clock.
module mcard_responder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TB_SECT    = 8;
    localparam int TB_NSEC    = 64;
    localparam int TB_TEST    = 5;
    localparam int MEM_AW     = $clog2(TB_NSEC) + $clog2(TB_SECT);
    localparam int MEM_SIZE   = TB_NSEC * TB_SECT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_active = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = 8'h00;
    logic [7:0]        flag_byte = 8'h08;
    logic [7:0]        tx_byte;
    logic              ack_en;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        mem_rd_data;
    logic              mem_wr_en;
    logic [7:0]        mem_wr_data;
    logic              dirty;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [7:0] mem [MEM_SIZE];
    int ref_mem [MEM_SIZE];

    // reference model state
    int  m_ph = 0, m_cnt = 0, m_op = 0, m_msb = 0, m_lsb = 0, m_chk = 0, m_host = 0;
    bit  m_dirty = 0;
    int  e_rep = 'hFF;
    bit  e_ack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcard_responder #(
        .SECTOR_BYTES (TB_SECT),
        .NUM_SECTORS  (TB_NSEC),
        .TEST_SECTOR  (TB_TEST)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_active  (sel_active),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .flag_byte   (flag_byte),
        .tx_byte     (tx_byte),
        .ack_en      (ack_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data),
        .dirty       (dirty)
    );

    assign mem_rd_data = mem[mem_addr];
    always @(posedge clk) if (mem_wr_en) mem[mem_addr] <= mem_wr_data;

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Model of one clock with the given inputs; returns tag and write expectation.
    task automatic model(input bit s, input bit v, input int b,
                         output string tag, output bit we, output int waddr);
        int addr;
        bit ok;
        we = 0; waddr = 0; tag = "R9";
        if (!s) begin
            m_ph = 0; m_cnt = 0; m_chk = 0; m_host = 0; m_msb = 0; m_lsb = 0;
            e_rep = 'hFF; e_ack = 0;
            return;
        end
        if (!v) begin
            tag = "R9";
            return;
        end
        addr = m_msb * 256 + m_lsb;
        ok = (addr < TB_NSEC);
        e_ack = 1;
        e_rep = 'hFF;
        case (m_ph)
            0: begin
                tag = "R1"; m_cnt = 0; m_chk = 0; m_host = 0;
                if (b == 'h81) begin e_rep = flag_byte; m_ph = 1; end
                else e_ack = 0;
            end
            1: begin
                tag = "R2";
                if (b == 'h52 || b == 'h57 || b == 'h53) begin
                    m_op = b; e_rep = 'h5A; m_ph = 2;
                end else begin
                    e_ack = 0; m_ph = 0;
                end
            end
            2: begin
                tag = "R3"; e_rep = 'h5D; m_cnt = 0;
                m_ph = (m_op == 'h53) ? 6 : 3;
            end
            3: begin
                tag = "R4";
                if (m_cnt == 0) begin e_rep = 0; m_cnt = 1; end
                else if (m_cnt == 1) begin m_msb = b; e_rep = b; m_cnt = 2; end
                else begin
                    m_lsb = b; m_cnt = 0;
                    e_rep = (m_op == 'h52) ? 'h5C : b;
                    m_ph  = (m_op == 'h52) ? 4 : 5;
                end
            end
            4: begin
                tag = "R5";
                if (m_cnt == 0) begin e_rep = 'h5D; m_chk = m_msb ^ m_lsb; end
                else if (m_cnt < 3) begin
                    if (ok) e_rep = (m_cnt == 1) ? m_msb : m_lsb;
                    else begin tag = "R8"; m_ph = 7; end
                end else if (m_cnt < TB_SECT + 3) begin
                    e_rep = ref_mem[addr * TB_SECT + m_cnt - 3];
                    m_chk = m_chk ^ e_rep;
                end else begin
                    tag = "R6"; e_rep = m_chk; m_ph = 8;
                end
                m_cnt++;
            end
            5: begin
                tag = "R7";
                if (!ok) begin tag = "R8"; m_ph = 7; end
                else begin
                    if (m_cnt == 0) m_chk = m_msb ^ m_lsb;
                    if (m_cnt < TB_SECT) begin
                        we = 1; waddr = addr * TB_SECT + m_cnt;
                        ref_mem[waddr] = b; m_chk = m_chk ^ b; e_rep = b;
                    end else if (m_cnt == TB_SECT) begin
                        m_host = b; e_rep = 'h5C;
                    end else begin
                        tag = "R10"; e_rep = 'h5D; m_ph = 8;
                        if (addr != TB_TEST) m_dirty = 1;
                    end
                    m_cnt++;
                end
            end
            6: begin
                tag = "R3";
                if (m_cnt < 6) begin
                    case (m_cnt)
                        0: e_rep = 'h5C;
                        1: e_rep = 'h5D;
                        2: e_rep = 'h04;
                        5: e_rep = 'h80;
                        default: e_rep = 'h00;
                    endcase
                    m_cnt++;
                end else begin
                    e_ack = 0; m_ph = 0;
                end
            end
            7: begin tag = "R8"; m_ph = 0; end
            default: begin
                tag = "R6";
                e_rep = (m_host == m_chk) ? 'h47 : 'h4E;
                m_ph = 0;
            end
        endcase
    endtask

    // One clock: drive at the falling edge, check write strobe, then registered outputs.
    task automatic step(input bit s, input bit v, input logic [7:0] b);
        string tag;
        bit we;
        int waddr;
        sel_active = s; rx_valid = v; rx_byte = b;
        model(s, v, b, tag, we, waddr);
        #1;
        check(we ? "R7" : tag, "mem_wr_en", mem_wr_en, we);
        if (we) begin
            check("R7", "mem_addr", mem_addr, waddr);
            check("R7", "mem_wr_data", mem_wr_data, b);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "tx_byte", tx_byte, e_rep);
        check(tag, "ack_en", ack_en, e_ack);
        check("R10", "dirty", dirty, m_dirty);
    endtask

    task automatic run_frame(input logic [7:0] q[$]);
        foreach (q[i]) begin
            step(1, 1, q[i]);
            step(1, 0, 8'h00);
        end
        step(0, 0, 8'h00);
    endtask

    task automatic do_write(input int sec, input logic [7:0] d[$], input bit bad);
        logic [7:0] fq[$];
        logic [7:0] c;
        c = 8'(sec >> 8) ^ 8'(sec);
        foreach (d[i]) c = c ^ d[i];
        if (bad) c = c ^ 8'h01;
        fq = '{8'h81, 8'h57, 8'h00, 8'h00, 8'(sec >> 8), 8'(sec)};
        foreach (d[i]) fq.push_back(d[i]);
        fq.push_back(c);
        fq.push_back(8'h00);
        fq.push_back(8'h00);
        fq.push_back(8'h00);
        run_frame(fq);
    endtask

    task automatic do_read(input int sec);
        logic [7:0] fq[$];
        fq = '{8'h81, 8'h52, 8'h00, 8'h00, 8'(sec >> 8), 8'(sec)};
        for (int i = 0; i < TB_SECT + 6; i++) fq.push_back(8'h00);
        run_frame(fq);
    endtask

    function automatic void fill(ref logic [7:0] d[$], input int base, input int stride);
        d = {};
        for (int i = 0; i < TB_SECT; i++) d.push_back(8'(base + i * stride));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d[$];
        for (int i = 0; i < MEM_SIZE; i++) begin
            mem[i] = 8'((i * 29 + 7) ^ (i >> 3));
            ref_mem[i] = int'(mem[i]);
        end
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "tx_byte", tx_byte, 'hFF);
        check("R11", "ack_en", ack_en, 0);
        check("R11", "dirty", dirty, 0);
        check("R11", "mem_wr_en", mem_wr_en, 0);
        rst_n = 1'b1;
        step(0, 0, 8'h00);

        // R1: bytes other than the start byte are not answered
        run_frame('{8'h01, 8'h42, 8'h00});
        // R3: identify sequence and trailing byte
        run_frame('{8'h81, 8'h53, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                    8'h00, 8'h00, 8'h00, 8'h00});
        // R2: unknown command, then a late start byte in the same frame
        flag_byte = 8'h00;
        run_frame('{8'h81, 8'h99, 8'h81, 8'h53, 8'h00});
        // R10: writing the test sector leaves dirty low
        fill(d, 3, 5);
        do_write(TB_TEST, d, 0);
        // R7/R10: ordinary write raises dirty
        fill(d, 17, 11);
        do_write(7, d, 0);
        do_read(7);
        // R6: read whose checksum folds to zero ends GOOD
        d = {};
        d.push_back(8'h09);
        for (int i = 1; i < TB_SECT; i++) d.push_back(8'h00);
        do_write(9, d, 0);
        do_read(9);
        // R5: read of an untouched sector
        do_read(3);
        // R6/R7: write with a wrong host checksum
        fill(d, 200, 3);
        do_write(2, d, 1);
        do_read(2);
        // R8: out-of-range read and write
        do_read(TB_NSEC);
        fill(d, 1, 1);
        do_write(16'h0100, d, 0);
        // R9: deselect mid-frame, then a full frame works
        run_frame('{8'h81, 8'h52, 8'h00, 8'h00});
        run_frame('{8'h81, 8'h57, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h33});
        do_read(10);
        step(1, 1, 8'h81);
        step(0, 1, 8'h52);
        step(0, 0, 8'h00);
        finish_run();
    end

endmodule